// File: doc/BRIEF.md
# Coprocessor Handshake Responder

This block sits on the coprocessor side of a three-wire handshake with a host processor. The host pulls an active-low instruction strobe whenever it begins executing a coprocessor instruction. A pipeline follower supplies a copy of that instruction. The responder compares the coprocessor-number field of the instruction with its own fixed identity. When the two match, it claims the instruction by pulling its "absent" line low.

While it holds "absent" low, the responder keeps the "busy" line high until its execution unit reports that it is ready. It then drops "busy". When the strobe and both lines are all sampled low on a rising clock edge, the instruction is committed and the block emits a one-cycle commit pulse. That pulse carries a companion transfer pulse unless the instruction is a pure data operation, which finishes with no transfer cycles.

If the host raises the strobe before commit, it has broken off to take an interrupt. The claimed instruction is then thrown away with a discard pulse and is never resumed. Both line outputs are active-low drive enables, so several responders with distinct identities can share the lines through a wired-AND.

Top module: `cpx_handshake_responder`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, the absent and busy drives are high (released) and the commit, transfer and discard pulses are low.
- R2: On a rising edge that samples the strobe low while instruction bits [11:8] equal the block's identity (in the idle state), the absent drive goes low from the next cycle and the busy drive stays high.
- R3: On an edge that samples the strobe low while instruction bits [11:8] differ from the identity, both drives stay high and no pulse is produced.
- R4: The busy drive is low only while the absent drive is low. It goes low on the cycle after an edge that samples the ready input high while the block holds a claim.
- R5: On an edge that samples the strobe low while both drives are low, the commit pulse is high for exactly the next cycle, and both drives are released high in that same cycle.
- R6: The transfer pulse is high together with the commit pulse when the data-operation flag sampled at the claim edge was 0. It stays low when that flag was 1, in which case the commit pulse alone marks completion.
- R7: On an edge that samples the strobe high while the block holds a claim, either still busy or already ready, the discard pulse is high for exactly the next cycle, both drives are released, and no commit pulse follows.
- R8: After a commit, the block makes no new claim until it has sampled the strobe high at least once.
- R9: The ready input has no effect while no claim is held: the busy drive stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all lines sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_n | input | 1 | Active-low coprocessor-instruction strobe from the host |
| insn | input | INSN_W | Current instruction word from the pipeline follower |
| dataop | input | 1 | High when the current instruction is a data operation with no transfer |
| exec_ready | input | 1 | Execution unit is ready to complete the claimed instruction |
| absent_drv_n | output | 1 | Active-low drive of the shared absent line (low = claimed) |
| busy_drv_n | output | 1 | Active-low drive of the shared busy line (low = ready) |
| commit_p | output | 1 | One-cycle pulse: instruction committed |
| xfer_p | output | 1 | One-cycle pulse with commit when data transfers follow |
| discard_p | output | 1 | One-cycle pulse: claimed instruction abandoned |

## Verification
The bench builds two responders with 32-bit instruction words and sixteen possible identities. The device under test has identity 5 and a peer has identity 12, and their drives are joined by a wired-AND. This setup shows that one instruction is claimed by exactly one of the two while the other leaves the shared lines alone, and it lets each number be exercised as both a match and a mismatch. Keeping both instances at a 4-bit field at bits [11:8] covers the full identity width, so the highest identity (15) and the lowest (0) can be driven as foreign numbers against both instances.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  // Handshake state of one responder.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no claim held
    ST_CLAIM = 2'd1,  // absent low, busy high
    ST_READY = 2'd2,  // absent low, busy low
    ST_SPENT = 2'd3   // committed, waiting for strobe release
  } hs_state_e;

endpackage

// File: rtl/cpx_rst_sync.sv
module cpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cpx_id_match.sv
module cpx_id_match #(
  parameter int INSN_W    = 32,
  parameter int FIELD_LSB = 8,
  parameter int ID_W      = 4,
  parameter int CP_ID     = 5
) (
  input  logic [INSN_W-1:0] insn,
  output logic              id_hit
);

  localparam logic [ID_W-1:0] OWN_ID = ID_W'(CP_ID);

  logic [ID_W-1:0] field;
  logic            unused_insn_bits;

  assign field            = insn[FIELD_LSB +: ID_W];
  assign unused_insn_bits = ^insn;
  assign id_hit           = (field == OWN_ID);

endmodule

// File: rtl/cpx_hs_fsm.sv
module cpx_hs_fsm
  import cpx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_n,
  input  logic      id_hit,
  input  logic      dataop,
  input  logic      exec_ready,
  output hs_state_e state,
  output logic      dataop_q,
  output logic      commit_evt,
  output logic      discard_evt
);

  hs_state_e state_d;
  logic      claim_en;

  // Next-state process.
  always_comb begin
    state_d     = state;
    claim_en    = 1'b0;
    commit_evt  = 1'b0;
    discard_evt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!strobe_n && id_hit) begin
          state_d  = ST_CLAIM;
          claim_en = 1'b1;
        end
      end
      ST_CLAIM: begin
        if (strobe_n) begin
          state_d     = ST_IDLE;
          discard_evt = 1'b1;
        end else if (exec_ready) begin
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (strobe_n) begin
          state_d     = ST_IDLE;
          discard_evt = 1'b1;
        end else begin
          // strobe, absent and busy all low at this edge
          state_d    = ST_SPENT;
          commit_evt = 1'b1;
        end
      end
      ST_SPENT: begin
        if (strobe_n) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataop_q <= 1'b0;
    end else if (claim_en) begin
      dataop_q <= dataop;
    end
  end

endmodule

// File: rtl/cpx_line_out.sv
module cpx_line_out
  import cpx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_e state,
  input  logic      dataop_q,
  input  logic      commit_evt,
  input  logic      discard_evt,
  output logic      absent_drv_n,
  output logic      busy_drv_n,
  output logic      commit_p,
  output logic      xfer_p,
  output logic      discard_p
);

  logic commit_d;
  logic xfer_d;
  logic discard_d;

  // Line drives decode straight from the state register.
  assign absent_drv_n = !((state == ST_CLAIM) || (state == ST_READY));
  assign busy_drv_n   = !(state == ST_READY);

  always_comb begin
    commit_d  = commit_evt;
    xfer_d    = commit_evt && !dataop_q;
    discard_d = discard_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_p  <= 1'b0;
      xfer_p    <= 1'b0;
      discard_p <= 1'b0;
    end else begin
      commit_p  <= commit_d;
      xfer_p    <= xfer_d;
      discard_p <= discard_d;
    end
  end

endmodule

// File: rtl/cpx_handshake_responder.sv
module cpx_handshake_responder
  import cpx_pkg::*;
#(
  parameter int INSN_W    = 32,
  parameter int NUM_CP    = 16,
  parameter int FIELD_LSB = 8,
  parameter int CP_ID     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [INSN_W-1:0] insn,
  input  logic              dataop,
  input  logic              exec_ready,
  output logic              absent_drv_n,
  output logic              busy_drv_n,
  output logic              commit_p,
  output logic              xfer_p,
  output logic              discard_p
);

  localparam int ID_W = $clog2(NUM_CP);

  logic      rst_n_sync;
  logic      id_hit;
  hs_state_e state;
  logic      dataop_q;
  logic      commit_evt;
  logic      discard_evt;

  cpx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cpx_id_match #(
    .INSN_W    (INSN_W),
    .FIELD_LSB (FIELD_LSB),
    .ID_W      (ID_W),
    .CP_ID     (CP_ID)
  ) u_match (
    .insn   (insn),
    .id_hit (id_hit)
  );

  cpx_hs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .strobe_n    (strobe_n),
    .id_hit      (id_hit),
    .dataop      (dataop),
    .exec_ready  (exec_ready),
    .state       (state),
    .dataop_q    (dataop_q),
    .commit_evt  (commit_evt),
    .discard_evt (discard_evt)
  );

  cpx_line_out u_out (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .state        (state),
    .dataop_q     (dataop_q),
    .commit_evt   (commit_evt),
    .discard_evt  (discard_evt),
    .absent_drv_n (absent_drv_n),
    .busy_drv_n   (busy_drv_n),
    .commit_p     (commit_p),
    .xfer_p       (xfer_p),
    .discard_p    (discard_p)
  );

endmodule

// File: rtl/cpx_handshake_checker.sv
module cpx_handshake_checker #(
  parameter int INSN_W    = 32,
  parameter int NUM_CP    = 16,
  parameter int FIELD_LSB = 8,
  parameter int CP_ID     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_n,
  input logic [INSN_W-1:0] insn,
  input logic              exec_ready,
  input logic              absent_drv_n,
  input logic              busy_drv_n,
  input logic              commit_p,
  input logic              xfer_p,
  input logic              discard_p
);

  localparam int ID_W = $clog2(NUM_CP);
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(CP_ID);

  // R2 / R3: a claim only follows a sampled low strobe carrying our number.
  assert_claim_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(absent_drv_n) |-> ($past(!strobe_n) && ($past(insn[FIELD_LSB +: ID_W]) == OWN_ID)));

  // R4: busy only released while absent is held low.
  assert_busy_under_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_drv_n |-> !absent_drv_n);

  // R4: busy release follows a sampled ready.
  assert_busy_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_drv_n) |-> $past(exec_ready));

  // R5: commit only after strobe and both lines were low, and lines released.
  assert_commit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_p |-> ($past(!strobe_n) && $past(!busy_drv_n) && $past(!absent_drv_n)
                  && absent_drv_n && busy_drv_n));

  // R6: transfer pulse never without commit.
  assert_xfer_with_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_p |-> commit_p);

  // R7: discard only after strobe high during a claim; never with commit.
  assert_discard_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discard_p |-> ($past(strobe_n) && $past(!absent_drv_n) && !commit_p && absent_drv_n));

  // R8: no new claim on the cycle straight after a commit.
  assert_no_reclaim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_p |=> absent_drv_n);

endmodule

bind cpx_handshake_responder cpx_handshake_checker #(
  .INSN_W    (INSN_W),
  .NUM_CP    (NUM_CP),
  .FIELD_LSB (FIELD_LSB),
  .CP_ID     (CP_ID)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_n     (strobe_n),
  .insn         (insn),
  .exec_ready   (exec_ready),
  .absent_drv_n (absent_drv_n),
  .busy_drv_n   (busy_drv_n),
  .commit_p     (commit_p),
  .xfer_p       (xfer_p),
  .discard_p    (discard_p)
);

// File: tb/cpx_handshake_responder_tb.sv
`timescale 1ns/1ps
module cpx_handshake_responder_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         strobe_n;
  logic [W-1:0] insn;
  logic         dataop;
  logic         exec_ready;
  logic         peer_ready;

  logic a_n, b_n, c_p, x_p, d_p;
  logic pa_n, pb_n, pc_p, px_p, pd_p;
  logic line_absent, line_busy;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  cpx_handshake_responder #(.INSN_W(W), .NUM_CP(16), .FIELD_LSB(8), .CP_ID(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .insn(insn), .dataop(dataop),
    .exec_ready(exec_ready), .absent_drv_n(a_n), .busy_drv_n(b_n),
    .commit_p(c_p), .xfer_p(x_p), .discard_p(d_p));

  cpx_handshake_responder #(.INSN_W(W), .NUM_CP(16), .FIELD_LSB(8), .CP_ID(12)) u_peer (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .insn(insn), .dataop(dataop),
    .exec_ready(peer_ready), .absent_drv_n(pa_n), .busy_drv_n(pb_n),
    .commit_p(pc_p), .xfer_p(px_p), .discard_p(pd_p));

  assign line_absent = a_n & pa_n;
  assign line_busy   = b_n & pb_n;

  function automatic logic [W-1:0] mk(input int id);
    return 32'hE000_0010 | (W'(id & 15) << 8);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // advance one edge; inputs change and outputs are read 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    strobe_n = 1'b1; insn = '0; dataop = 1'b0; exec_ready = 1'b0; peer_ready = 1'b0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1 absent in reset", a_n, 1'b1);
    chk("R1 busy in reset", b_n, 1'b1);
    chk("R1 commit in reset", c_p, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 discard after release", d_p, 1'b0);
    chk("R1 absent after release", a_n, 1'b1);
    repeat (3) step();
  endtask

  task automatic t_commit(input logic dop);
    strobe_n = 1'b0; insn = mk(5); dataop = dop;
    step();
    chk("R2 absent claimed", a_n, 1'b0);
    chk("R2 busy held high", b_n, 1'b1);
    chk("R2 shared absent line", line_absent, 1'b0);
    dataop = ~dop;  // change after claim edge; must not matter
    step();
    chk("R4 still busy without ready", b_n, 1'b1);
    exec_ready = 1'b1;
    step();
    chk("R4 busy released", b_n, 1'b0);
    chk("R4 absent still low", a_n, 1'b0);
    exec_ready = 1'b0;
    step();
    chk("R5 commit pulse", c_p, 1'b1);
    chk("R5 absent released", a_n, 1'b1);
    chk("R5 busy released", b_n, 1'b1);
    chk(dop ? "R6 no xfer for data op" : "R6 xfer with commit", x_p, !dop);
    chk("R7 no discard on commit", d_p, 1'b0);
    step();  // strobe still low, same matching insn
    chk("R5 commit one cycle", c_p, 1'b0);
    chk("R8 no reclaim while strobe low", a_n, 1'b1);
    strobe_n = 1'b1;
    step();
    chk("R8 still idle", a_n, 1'b1);
    dataop = 1'b0;
  endtask

  task automatic t_foreign(input int id);
    strobe_n = 1'b0; insn = mk(id);
    step();
    chk("R3 absent stays high", a_n, 1'b1);
    chk("R3 busy stays high", b_n, 1'b1);
    step();
    chk("R3 no pulse", c_p | d_p | x_p, 1'b0);
    strobe_n = 1'b1;
    step();
  endtask

  task automatic t_peer();
    strobe_n = 1'b0; insn = mk(12);
    step();
    chk("R3 dut ignores peer number", a_n, 1'b1);
    chk("R2 peer claims its number", pa_n, 1'b0);
    chk("R2 shared absent low via peer", line_absent, 1'b0);
    peer_ready = 1'b1;
    step();
    chk("R4 shared busy low via peer", line_busy, 1'b0);
    chk("R9 dut busy untouched", b_n, 1'b1);
    peer_ready = 1'b0;
    step();
    chk("R5 peer commits", pc_p, 1'b1);
    chk("R3 dut no commit", c_p, 1'b0);
    strobe_n = 1'b1;
    step();
  endtask

  task automatic t_discard(input logic when_ready);
    strobe_n = 1'b0; insn = mk(5);
    step();
    if (when_ready) begin
      exec_ready = 1'b1;
      step();
      chk("R7 reached ready", b_n, 1'b0);
      exec_ready = 1'b0;
    end
    strobe_n = 1'b1;  // host breaks off
    step();
    chk(when_ready ? "R7 discard from ready" : "R7 discard while busy", d_p, 1'b1);
    chk("R7 no commit", c_p, 1'b0);
    chk("R7 absent released", a_n, 1'b1);
    chk("R7 busy released", b_n, 1'b1);
    step();
    chk("R7 discard one cycle", d_p, 1'b0);
    chk("R7 no late commit", c_p, 1'b0);
  endtask

  task automatic t_idle_ready();
    exec_ready = 1'b1; strobe_n = 1'b1; insn = mk(5);
    step();
    step();
    chk("R9 busy high when idle", b_n, 1'b1);
    chk("R9 absent high when idle", a_n, 1'b1);
    exec_ready = 1'b0;
    step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_commit(1'b0);
    t_commit(1'b1);
    t_foreign(4);
    t_foreign(15);
    t_foreign(0);
    t_peer();
    t_discard(1'b0);
    t_discard(1'b1);
    t_idle_ready();
    t_commit(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule